// File: doc/BRIEF.md
# Three-Wire-Plus-Output Serial EEPROM Slave Model

This block is a synthesizable stand-in for a small serial EEPROM holding 64 words of 16 bits. A host talks to it over a four-wire Microwire link: a select line, a serial clock, a data input and a data output with its own output-enable. The storage is a simple dual-port register array, so an FPGA tool can map it to block RAM. All pins are brought into the system clock domain through synchronizers. Serial clock edges are detected there, so the serial clock has to be well below the system clock rate.

While select is high, each command is shifted in on rising serial clock edges. A command is a start bit, then a two-bit opcode, then a six-bit address, then data where the command takes it. The block can read with automatic address advance, write one word, erase one word, write one value to every word, erase every word, and set or clear a write-enable latch. A program command runs for a fixed number of system clocks after select falls. During that time, raising select shows busy (0) or ready (1) on the data output.

Top module: `mw_eeprom_slave`

## Requirements
- R1: Rising serial clock edges that sample DI low while no command is open are ignored. The first sampled 1 is taken as the start bit.
- R2: After the start bit come two opcode bits and then six address bits, MSB first. The opcodes are 10 read, 01 write and 11 erase. Opcode 00 selects by address bits [5:4]: 01 write-all, 10 erase-all, 11 write enable, 00 write disable. Address bits [3:0] are ignored for these four.
- R3: On a read, the output is enabled and drives 0 once the last address bit has been sampled. Each later rising serial clock edge then presents the next bit of the addressed word, MSB first.
- R4: While select stays high, a read carries on into the following word with no gap. After address 63 it continues at address 0.
- R5: Write and write-all store the last 16 data bits received before select falls, however many bits were sent.
- R6: Erase sets the addressed word to 16'hFFFF. Erase-all sets every word to 16'hFFFF. Write-all stores its data in every word.
- R7: A program operation starts only when select falls after a complete command. If select falls before all address and data bits have arrived, the command is discarded and memory is unchanged.
- R8: While a program operation runs, serial clock and DI activity is ignored, including a full command sent during that time.
- R9: After a program command, raising select enables the output. It drives 0 while programming and 1 once programming is done. A start bit sampled after completion turns the output off again.
- R10: After reset the write-enable latch is clear, and program commands are then refused: no program starts and no busy status appears. The write-enable and write-disable commands set and clear the latch.
- R11: While select is low the output enable is low, and serial clock and DI are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock; DI is sampled on its rising edge |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out (read data or busy/ready status) |
| sdo_oe_o | output | 1 | Output enable for sdo_o; low means high impedance |

## Verification
The bench aims at the places where a small slip in the shift logic would go unnoticed in normal use. Leading dummy clocks must not be taken as the start bit. A data stream longer than 16 bits must keep its tail; a design that kept the head would store the wrong word. A sequential read must cross from word 63 to word 0, which fails if the increment saturates. Commands that are cut short, refused while the latch is clear, or sent during a program cycle must leave both the memory and the busy status untouched; a design that accepted them would show a busy output or changed words on the next read. The status phase is checked before and after a new start bit, to catch an output that never releases.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_OPC,
    S_ADDR,
    S_DATA,
    S_HOLD,
    S_READ,
    S_PROG
  } mw_state_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] SUB_WDIS = 2'b00;
  localparam logic [1:0] SUB_WALL = 2'b01;
  localparam logic [1:0] SUB_EALL = 2'b10;
  localparam logic [1:0] SUB_WEN  = 2'b11;

endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic cs_o,
  output logic cs_fall_o,
  output logic sck_rise_o,
  output logic sdi_o
);

  logic [STAGES-1:0] cs_p, sk_p, di_p;
  logic cs_d, sk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p <= '0;
      sk_p <= '0;
      di_p <= '0;
      cs_d <= 1'b0;
      sk_d <= 1'b0;
    end else begin
      cs_p <= {cs_p[STAGES-2:0], cs_i};
      sk_p <= {sk_p[STAGES-2:0], sck_i};
      di_p <= {di_p[STAGES-2:0], sdi_i};
      cs_d <= cs_p[STAGES-1];
      sk_d <= sk_p[STAGES-1];
    end
  end

  assign cs_o       = cs_p[STAGES-1];
  assign cs_fall_o  = cs_d & ~cs_p[STAGES-1];
  assign sck_rise_o = sk_p[STAGES-1] & ~sk_d;
  assign sdi_o      = di_p[STAGES-1];

endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int LEN = 400,
  localparam int CW = $clog2(LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] count_o
);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign done_o  = busy_q && (cnt_q == CW'(LEN - 1));
  assign busy_o  = busy_q;
  assign count_o = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (done_o) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  // R7: a finished program cycle releases busy on the following clock
  p_release_after_done_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !busy_o);

  // R8: the count never leaves the programmed window
  p_count_in_window_r8: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (cnt_q < CW'(LEN)));

endmodule

// File: rtl/mw_word_ram.sv
module mw_word_ram #(
  parameter int AW = 6,
  parameter int DW = 16,
  localparam int WORDS = 1 << AW
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
  import mw_pkg::*;
#(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_oe_o
);

  localparam int WORDS    = 1 << AW;
  localparam int PROG_LEN = (PROG_CYCLES > WORDS) ? PROG_CYCLES : WORDS + 1;
  localparam int TCW      = $clog2(PROG_LEN + 1);
  localparam int CNTW     = $clog2(DW + 1);
  localparam int BPW      = $clog2(DW);

  logic cs_s, cs_fall, sk_rise, di_s;

  mw_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .cs_i      (cs_i),
    .sck_i     (sck_i),
    .sdi_i     (sdi_i),
    .cs_o      (cs_s),
    .cs_fall_o (cs_fall),
    .sck_rise_o(sk_rise),
    .sdi_o     (di_s)
  );

  logic           prog_go_q;
  logic           t_busy, t_done;
  logic [TCW-1:0] t_count;

  mw_prog_timer #(.LEN(PROG_LEN)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start_i(prog_go_q),
    .busy_o (t_busy),
    .done_o (t_done),
    .count_o(t_count)
  );

  mw_state_e      state_q;
  logic [CNTW-1:0] cnt_q;
  logic [1:0]     op_q;
  logic [AW-1:0]  addr_q, prog_addr_q, rd_addr_q;
  logic [DW-1:0]  data_q, rd_word;
  logic [BPW-1:0] bitpos_q;
  logic           wen_q, pend_q, bulk_q, rd_act_q, rd_bit_q, stat_q;
  logic [AW-1:0]  addr_nx;
  logic [1:0]     sub_nx;
  logic           cmd_complete;

  logic           mem_we;
  logic [AW-1:0]  mem_waddr;

  assign addr_nx      = {addr_q[AW-2:0], di_s};
  assign sub_nx       = addr_nx[AW-1 -: 2];
  assign cmd_complete = ((state_q == S_DATA) && (cnt_q == CNTW'(DW))) ||
                        ((state_q == S_HOLD) && pend_q);

  // program write port: one word, or a sweep over every word for bulk commands
  assign mem_we    = t_busy && (bulk_q ? (t_count < TCW'(WORDS)) : (t_count == '0));
  assign mem_waddr = bulk_q ? t_count[AW-1:0] : prog_addr_q;

  mw_word_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk    (clk),
    .we_i   (mem_we),
    .waddr_i(mem_waddr),
    .wdata_i(data_q),
    .raddr_i(rd_addr_q),
    .rdata_o(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      cnt_q       <= '0;
      op_q        <= '0;
      addr_q      <= '0;
      data_q      <= '0;
      prog_addr_q <= '0;
      rd_addr_q   <= '0;
      bitpos_q    <= '0;
      wen_q       <= 1'b0;
      pend_q      <= 1'b0;
      bulk_q      <= 1'b0;
      rd_act_q    <= 1'b0;
      rd_bit_q    <= 1'b0;
      stat_q      <= 1'b0;
      prog_go_q   <= 1'b0;
    end else begin
      prog_go_q <= 1'b0;
      if (state_q == S_PROG) begin
        if (t_done) state_q <= S_IDLE;
      end else if (cs_fall) begin
        rd_act_q <= 1'b0;
        pend_q   <= 1'b0;
        if (cmd_complete && wen_q) begin
          prog_go_q   <= 1'b1;
          stat_q      <= 1'b1;
          prog_addr_q <= addr_q;
          state_q     <= S_PROG;
        end else begin
          state_q <= S_IDLE;
        end
      end else if (cs_s && sk_rise) begin
        unique case (state_q)
          S_IDLE: begin
            if (di_s) begin
              state_q <= S_OPC;
              cnt_q   <= '0;
              stat_q  <= 1'b0;
            end
          end
          S_OPC: begin
            op_q <= {op_q[0], di_s};
            if (cnt_q == CNTW'(1)) begin
              state_q <= S_ADDR;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          S_ADDR: begin
            addr_q <= addr_nx;
            if (cnt_q == CNTW'(AW - 1)) begin
              cnt_q <= '0;
              unique case (op_q)
                OP_READ: begin
                  state_q   <= S_READ;
                  rd_addr_q <= addr_nx;
                  bitpos_q  <= BPW'(DW - 1);
                  rd_act_q  <= 1'b1;
                  rd_bit_q  <= 1'b0;
                end
                OP_WRITE: begin
                  state_q <= S_DATA;
                  bulk_q  <= 1'b0;
                end
                OP_ERASE: begin
                  state_q <= S_HOLD;
                  bulk_q  <= 1'b0;
                  data_q  <= '1;
                  pend_q  <= 1'b1;
                end
                default: begin
                  unique case (sub_nx)
                    SUB_WALL: begin
                      state_q <= S_DATA;
                      bulk_q  <= 1'b1;
                    end
                    SUB_EALL: begin
                      state_q <= S_HOLD;
                      bulk_q  <= 1'b1;
                      data_q  <= '1;
                      pend_q  <= 1'b1;
                    end
                    SUB_WEN: begin
                      state_q <= S_HOLD;
                      wen_q   <= 1'b1;
                    end
                    default: begin
                      state_q <= S_HOLD;
                      wen_q   <= 1'b0;
                    end
                  endcase
                end
              endcase
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          S_DATA: begin
            data_q <= {data_q[DW-2:0], di_s};
            if (cnt_q != CNTW'(DW)) cnt_q <= cnt_q + 1'b1;
          end
          S_READ: begin
            rd_bit_q <= rd_word[bitpos_q];
            if (bitpos_q == '0) begin
              bitpos_q  <= BPW'(DW - 1);
              rd_addr_q <= rd_addr_q + 1'b1;
            end else begin
              bitpos_q <= bitpos_q - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // registered pin drivers
  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_oe_o <= 1'b0;
      sdo_o    <= 1'b0;
    end else begin
      sdo_oe_o <= cs_s && (rd_act_q || stat_q);
      sdo_o    <= rd_act_q ? rd_bit_q : ~t_busy;
    end
  end

  // R11: select low releases the output
  p_release_on_deselect_r11: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> !sdo_oe_o);

  // R9: selected during programming shows busy as a driven low
  p_busy_status_r9: assert property (@(posedge clk) disable iff (rst)
    (t_busy && cs_s) |=> (sdo_oe_o && !sdo_o));

  // R8: command registers frozen while the timer runs
  p_frozen_while_busy_r8: assert property (@(posedge clk) disable iff (rst)
    t_busy |=> ($stable(addr_q) && $stable(op_q)));

  // R3: last address bit of a read starts the output with a leading zero
  p_read_lead_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_ADDR && op_q == OP_READ && cnt_q == CNTW'(AW - 1) && cs_s && sk_rise && !cs_fall)
    |=> (rd_act_q && !rd_bit_q && bitpos_q == BPW'(DW - 1)));

  // R4: the read address wraps from the top word to word 0
  p_read_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_READ && cs_s && sk_rise && !cs_fall && bitpos_q == '0 && rd_addr_q == '1)
    |=> (rd_addr_q == '0));

  // R10: the write-enable latch comes out of reset clear
  p_locked_after_reset_r10: assert property (@(posedge clk)
    $past(rst) |-> !wen_q);

endmodule

// File: tb/tb_mw_eeprom_slave.sv
module tb_mw_eeprom_slave;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic so, so_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] model [64];

  always #4 clk = ~clk;

  mw_eeprom_slave #(.AW(6), .DW(16), .PROG_CYCLES(1500), .SYNC_STAGES(2)) dut (
    .clk     (clk),
    .rst     (rst),
    .cs_i    (cs),
    .sck_i   (sk),
    .sdi_i   (di),
    .sdo_o   (so),
    .sdo_oe_o(so_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input bit b);
    di = b; tick(4);
    sk = 1'b1; tick(4);
    sk = 1'b0; tick(4);
  endtask

  task automatic bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) pulse(v[i]);
  endtask

  task automatic cs_hi;
    cs = 1'b1; tick(4);
  endtask

  task automatic cs_lo;
    cs = 1'b0; di = 1'b0; tick(6);
  endtask

  task automatic cmd(input logic [1:0] op, input logic [5:0] a);
    cs_hi();
    pulse(1'b1);
    bits(32'(op), 2);
    bits(32'(a), 6);
  endtask

  task automatic wait_ready(input string req);
    int lim;
    cs_hi();
    chk(so_oe === 1'b1 && so === 1'b0, req, {so_oe, so}, 2'b10);
    lim = 0;
    while (so !== 1'b1 && lim < 4000) begin
      tick(1);
      lim++;
    end
    chk(so_oe === 1'b1 && so === 1'b1, req, {so_oe, so}, 2'b11);
    cs_lo();
  endtask

  task automatic no_status(input string req);
    cs_hi();
    tick(4);
    chk(so_oe === 1'b0, req, so_oe, 0);
    cs_lo();
  endtask

  task automatic read_check(input int a, input int nw, input string req);
    logic [15:0] got;
    cmd(2'b10, 6'(a));
    chk(so_oe === 1'b1 && so === 1'b0, "R3 leading zero", {so_oe, so}, 2'b10);
    for (int w = 0; w < nw; w++) begin
      for (int b = 15; b >= 0; b--) begin
        pulse(1'b0);
        got[b] = so;
      end
      chk(got === model[(a + w) % 64], req, got, model[(a + w) % 64]);
    end
    cs_lo();
  endtask

  task automatic prog_write(input logic [5:0] a, input logic [31:0] d, input int n);
    cmd(2'b01, a);
    bits(d, n);
    cs_lo();
  endtask

  task automatic t_reset;
    chk(so_oe === 1'b0, "R11 reset output off", so_oe, 0);
  endtask

  task automatic t_locked;
    prog_write(6'd4, 32'h1234, 16);
    no_status("R10 refused while latch clear");
    cmd(2'b00, 6'b110000); cs_lo();
    cmd(2'b00, 6'b100101); cs_lo();
    wait_ready("R6 erase-all status");
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    read_check(0, 64, "R6 erase-all words");
  endtask

  task automatic t_dummy_overflow;
    cs_hi();
    pulse(1'b0); pulse(1'b0); pulse(1'b0);
    pulse(1'b1);
    bits(32'h1, 2);
    bits(32'd3, 6);
    bits(32'hF_A5C3, 20);
    cs_lo();
    wait_ready("R1 program after dummy clocks");
    model[3] = 16'hA5C3;
    read_check(3, 1, "R5 last 16 bits kept");
  endtask

  task automatic t_write_wrap;
    prog_write(6'd62, 32'hBEEF, 16); wait_ready("R2 write 62"); model[62] = 16'hBEEF;
    prog_write(6'd63, 32'h1357, 16); wait_ready("R2 write 63"); model[63] = 16'h1357;
    prog_write(6'd0,  32'h8001, 16); wait_ready("R2 write 0");  model[0]  = 16'h8001;
    prog_write(6'd1,  32'h7FFE, 16); wait_ready("R2 write 1");  model[1]  = 16'h7FFE;
    read_check(62, 4, "R4 sequential wrap");
  endtask

  task automatic t_erase;
    cmd(2'b11, 6'd62); cs_lo();
    wait_ready("R6 erase status");
    model[62] = 16'hFFFF;
    read_check(61, 3, "R6 single erase");
  endtask

  task automatic t_incomplete;
    prog_write(6'd5, 32'h0F0F, 10);
    no_status("R7 short data discarded");
    cs_hi(); pulse(1'b1); bits(32'h3, 2); bits(32'h0, 3); cs_lo();
    no_status("R7 short address discarded");
    read_check(5, 1, "R7 word unchanged");
  endtask

  task automatic t_busy_ignore;
    cmd(2'b01, 6'd10);
    bits(32'hC0DE, 16);
    cs_lo();
    cs_hi();
    chk(so_oe === 1'b1 && so === 1'b0, "R9 busy shown", {so_oe, so}, 2'b10);
    pulse(1'b1); bits(32'h1, 2); bits(32'd11, 6); bits(32'h4444, 16);
    chk(so_oe === 1'b1 && so === 1'b0, "R8 start bit ignored while busy", {so_oe, so}, 2'b10);
    cs_lo();
    wait_ready("R8 first command completes");
    model[10] = 16'hC0DE;
    cs_hi();
    chk(so_oe === 1'b1 && so === 1'b1, "R9 ready repeated", {so_oe, so}, 2'b11);
    pulse(1'b1);
    chk(so_oe === 1'b0, "R9 start bit releases output", so_oe, 0);
    cs_lo();
    read_check(10, 2, "R8 second command ignored");
  endtask

  task automatic t_wral;
    cmd(2'b00, 6'b011010);
    bits(32'h5AA5, 16);
    cs_lo();
    wait_ready("R6 write-all status");
    for (int i = 0; i < 64; i++) model[i] = 16'h5AA5;
    read_check(20, 3, "R6 write-all words");
    read_check(63, 2, "R6 write-all ends");
  endtask

  task automatic t_ewds;
    cmd(2'b00, 6'b001111); cs_lo();
    prog_write(6'd7, 32'h0000, 16);
    no_status("R10 refused after disable");
    cmd(2'b11, 6'd8); cs_lo();
    no_status("R10 erase refused after disable");
    read_check(7, 2, "R10 words kept");
  endtask

  task automatic t_cs_low;
    cs = 1'b0;
    for (int i = 0; i < 30; i++) pulse(1'b1);
    chk(so_oe === 1'b0, "R11 output off while deselected", so_oe, 0);
    read_check(7, 1, "R11 clean command after deselected clocks");
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(8 * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(5);
    t_reset();
    t_locked();
    t_dummy_overflow();
    t_write_wrap();
    t_erase();
    t_incomplete();
    t_busy_ignore();
    t_wral();
    t_ewds();
    t_cs_low();
    summary();
    $finish;
  end

endmodule